// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a bank of five down-counting timers behind a flat word-addressed register interface. It has one write port (address, data, enable) and one combinational read port (address, data). Channels 0 to 3 each drive one PWM pin. Channel 4 has no compare register and no pin, and acts as a plain countdown timer. Software writes a reload value and, for channels 0 to 3, a compare value into buffer registers. It pulses a per-channel load bit that copies the buffers into the working counter, then sets the run bit.

Counting is clocked by ticks, not by the raw clock. Two 8-bit prescalers divide the clock by (value + 1). The first serves channels 0 and 1, the second serves channels 2, 3 and 4. Each channel then applies its own power-of-two divider. A running channel counts from its reload value down to zero and raises its bit in the zero-event register. It then either reloads and continues, or parks at zero. The live count of every channel can be read back.

The register interface is a plain strobe interface that accepts a write every cycle and never stalls, so it has no valid/ready handshake. The PWM pins are plain level outputs.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads 0 and all four PWM pins are low.
- R2: The register map is at word addresses: 0 prescaler word, 1 divider word, 2 control, 3+3n / 4+3n / 5+3n reload buffer / compare buffer / live count of channel n (n=0..3), 15 reload buffer of channel 4, 16 live count of channel 4, 17 zero-event flags. The prescaler word bits [7:0] serve channels 0–1 and bits [15:8] serve channels 2–4. The divider word holds a 4-bit code for channel n at bits [4n+3:4n]. Buffers, prescaler, divider and control words read back what was written (prescaler 16 bits, divider 20 bits, others 32 bits).
- R3: While a channel's load bit is 1, its working counter and compare take the buffer values one cycle later, so the live count reads the reload buffer.
- R4: A running channel decrements once every (prescaler+1)·D clock cycles, where divider codes 0,1,2,3,4 give D = 1,2,4,8,16.
- R5: With auto-reload, a channel loaded with reload N and compare C gives a pin period of N+1 ticks. The pin is high for N−C ticks, from the reload until the count reaches C.
- R6: The invert bit flips the pin, so the high time becomes C+1 ticks and a stopped pin sits high.
- R7: With the run bit 0 (and load bit 0) the counter is frozen and the pin sits at its inactive level (low, or high if inverted).
- R8: Without auto-reload, a channel that reaches zero stays at zero.
- R9: When a running channel steps from 1 to 0 it sets zero-event bit n. Writing 1 to bit n clears it, unless a new event arrives in the same cycle.
- R10: Writes to live-count addresses change no register.
- R11: Channel 4 uses control bits 20 (run), 21 (load) and 22 (auto-reload), and has no compare and no pin.
- R12: In the control word, channel 0 owns bits [3:0] and channel n≥1 owns bits [4(n+1)+3 : 4(n+1)], ordered run, load, invert, auto-reload from the low bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | PWM pins of channels 0 to 3 |

## Verification
Randomly chosen prescaler and divider pairs on one group-two channel show whether the tick rate uses both factors and the right power of two. Random reload/compare pairs on channels 1 and 3 measure pin period and high time, with and without inversion, and separate off-by-one errors in the period from errors in the compare point. Directed one-shot runs, a mid-run stop, writes to read-only addresses and a channel 4 run test the zero parking, the event flag clearing, the freeze, and the irregular control bit positions.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NCH    = 5;
  localparam int NOUT   = 4;
  localparam int CNT_W  = 32;
  localparam int PRE_W  = 8;
  localparam int DIV_W  = 4;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_PRE  = 5'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 5'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd2;
  localparam logic [ADDR_W-1:0] A_EVT  = 5'd17;

  function automatic logic [ADDR_W-1:0] reload_addr(int n);
    return (n < NOUT) ? ADDR_W'(3 + 3*n) : ADDR_W'(15);
  endfunction
  function automatic logic [ADDR_W-1:0] cmp_addr(int n);
    return ADDR_W'(4 + 3*n);
  endfunction
  function automatic logic [ADDR_W-1:0] live_addr(int n);
    return (n < NOUT) ? ADDR_W'(5 + 3*n) : ADDR_W'(16);
  endfunction

  // control word layout: channel 0 at bit 0, channel n>=1 at 4*(n+1)
  function automatic int run_pos(int n);
    return (n == 0) ? 0 : 4*(n+1);
  endfunction
  function automatic int load_pos(int n);
    return run_pos(n) + 1;
  endfunction
  function automatic int inv_pos(int n);
    return run_pos(n) + 2;
  endfunction
  function automatic int arel_pos(int n);
    return (n == NCH-1) ? 22 : run_pos(n) + 3;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] limit,
  output logic          tick
);
  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int W  = 32,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tick,
  input  logic [DW-1:0] div_sel,
  input  logic          run,
  input  logic          load,
  input  logic          arel,
  input  logic          inv,
  input  logic [W-1:0]  reload_buf,
  input  logic [W-1:0]  cmp_buf,
  output logic [W-1:0]  count,
  output logic          zero_evt,
  output logic          pin
);
  localparam int DMAX_W = 4;

  logic [W-1:0]      cnt_q, cmp_q;
  logic              raw_q;
  logic [DMAX_W-1:0] dcnt_q, dmax;
  logic              step;

  always_comb begin
    if (div_sel >= DW'(4)) dmax = 4'd15;
    else                   dmax = DMAX_W'((1 << div_sel) - 1);
  end

  assign step     = run && pre_tick && (dcnt_q == dmax);
  assign zero_evt = step && !load && (cnt_q == W'(1));
  assign count    = cnt_q;
  assign pin      = run ? (raw_q ^ inv) : inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      raw_q  <= 1'b0;
      dcnt_q <= '0;
    end else if (load) begin
      cnt_q  <= reload_buf;
      cmp_q  <= cmp_buf;
      raw_q  <= 1'b1;
      dcnt_q <= '0;
    end else begin
      if (run && pre_tick)
        dcnt_q <= (dcnt_q == dmax) ? '0 : dcnt_q + 1'b1;
      if (step) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q - 1'b1 == cmp_q) raw_q <= 1'b0;
        end else if (arel) begin
          cnt_q <= reload_buf;
          cmp_q <= cmp_buf;
          raw_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NOUT-1:0]   pwm_out
);
  localparam int PRE_BITS = 2*PRE_W;
  localparam int DIV_BITS = NCH*DIV_W;

  logic [PRE_BITS-1:0]         pre_q;
  logic [DIV_BITS-1:0]         div_q;
  logic [CNT_W-1:0]            ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]   rbuf_q;
  logic [NCH-1:0][CNT_W-1:0]   cbuf_q;
  logic [NCH-1:0][CNT_W-1:0]   live;
  logic [NCH-1:0]              evt_q, zero_hit, pins;
  logic [1:0]                  grp_tick;
  logic                        unused_ch4_pin;

  for (genvar g = 0; g < 2; g++) begin : g_pre
    pwm_prescaler #(.PW(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n),
      .limit(pre_q[g*PRE_W +: PRE_W]),
      .tick(grp_tick[g])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_channel #(.W(CNT_W), .DW(DIV_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .pre_tick(n < 2 ? grp_tick[0] : grp_tick[1]),
      .div_sel(div_q[n*DIV_W +: DIV_W]),
      .run(ctrl_q[run_pos(n)]),
      .load(ctrl_q[load_pos(n)]),
      .arel(ctrl_q[arel_pos(n)]),
      .inv(n < NOUT ? ctrl_q[inv_pos(n)] : 1'b0),
      .reload_buf(rbuf_q[n]),
      .cmp_buf(cbuf_q[n]),
      .count(live[n]),
      .zero_evt(zero_hit[n]),
      .pin(pins[n])
    );
  end

  assign pwm_out        = pins[NOUT-1:0];
  assign unused_ch4_pin = pins[NCH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      div_q  <= '0;
      ctrl_q <= '0;
      rbuf_q <= '0;
      cbuf_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PRE)  pre_q  <= wr_data[PRE_BITS-1:0];
      if (wr_addr == A_DIV)  div_q  <= wr_data[DIV_BITS-1:0];
      if (wr_addr == A_CTRL) ctrl_q <= wr_data;
      for (int n = 0; n < NCH; n++) begin
        if (wr_addr == reload_addr(n)) rbuf_q[n] <= wr_data;
        if (n < NOUT && wr_addr == cmp_addr(n)) cbuf_q[n] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else if (wr_en && wr_addr == A_EVT)
      evt_q <= (evt_q & ~wr_data[NCH-1:0]) | zero_hit;
    else
      evt_q <= evt_q | zero_hit;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_PRE)  rd_data = CNT_W'(pre_q);
    if (rd_addr == A_DIV)  rd_data = CNT_W'(div_q);
    if (rd_addr == A_CTRL) rd_data = ctrl_q;
    if (rd_addr == A_EVT)  rd_data = CNT_W'(evt_q);
    for (int n = 0; n < NCH; n++) begin
      if (rd_addr == reload_addr(n)) rd_data = rbuf_q[n];
      if (n < NOUT && rd_addr == cmp_addr(n)) rd_data = cbuf_q[n];
      if (rd_addr == live_addr(n)) rd_data = live[n];
    end
  end
endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk
  import pwm_timer_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [CNT_W-1:0]          ctrl,
  input logic [NCH-1:0][CNT_W-1:0] rbuf,
  input logic [NCH-1:0][CNT_W-1:0] live,
  input logic [NCH-1:0]            evt
);
  for (genvar n = 0; n < NCH; n++) begin : g_a
    assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[load_pos(n)] |=> live[n] == $past(rbuf[n]));

    assert_stopped_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[run_pos(n)] && !ctrl[load_pos(n)]) |=> $stable(live[n]));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[run_pos(n)] && !ctrl[load_pos(n)] && live[n] != '0)
        |=> (live[n] == $past(live[n]) || live[n] == $past(live[n]) - 1'b1));

    assert_oneshot_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[run_pos(n)] && !ctrl[load_pos(n)] && !ctrl[arel_pos(n)] && live[n] == '0)
        |=> live[n] == '0);

    assert_zero_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[run_pos(n)] && !ctrl[load_pos(n)] && live[n] == CNT_W'(1))
        |=> (live[n] == CNT_W'(1) || evt[n]));
  end
endmodule

bind pwm_timer_bank pwm_timer_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .rbuf(rbuf_q), .live(live), .evt(evt_q)
);

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] ctl = '0, pre_s = '0, div_s = '0;

  pwm_timer_bank u_dut (.*);

  always #4 clk = ~clk;

  function automatic int runb(int n);  return n == 0 ? 0 : 4*(n+1); endfunction
  function automatic int arelb(int n); return n == 4 ? 22 : runb(n) + 3; endfunction
  function automatic logic [4:0] a_rel(int n);  return n < 4 ? 5'(3+3*n) : 5'd15; endfunction
  function automatic logic [4:0] a_cmp(int n);  return 5'(4+3*n); endfunction
  function automatic logic [4:0] a_live(int n); return n < 4 ? 5'(5+3*n) : 5'd16; endfunction
  function automatic int tick_len(int p, int code);
    return (p + 1) * (1 << (code > 4 ? 4 : code));
  endfunction
  function automatic int exp_high(int nv, int cv, bit inv);
    return inv ? cv + 1 : nv - cv;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic arm(int n, int nv, int cv, int p, int code, bit ar, bit inv);
    wr(a_rel(n), nv);
    if (n < 4) wr(a_cmp(n), cv);
    if (n < 2) pre_s[7:0] = p[7:0]; else pre_s[15:8] = p[7:0];
    wr(5'd0, pre_s);
    div_s[4*n +: 4] = code[3:0];
    wr(5'd1, div_s);
    for (int b = 0; b < 4; b++) ctl[runb(n)+b] = 1'b0;
    if (n == 4) ctl[22] = 1'b0;
    ctl[runb(n)+1] = 1'b1;
    if (n < 4) ctl[runb(n)+2] = inv;
    ctl[arelb(n)] = ar;
    wr(5'd2, ctl);
    ctl[runb(n)+1] = 1'b0;
    ctl[runb(n)]   = 1'b1;
    wr(5'd2, ctl);
  endtask

  task automatic measure(int n, output int hi, output int per);
    int guard = 0;
    logic prev, cur;
    hi = 0; per = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk); #1 cur = pwm_out[n];
      if (!prev && cur) break;
      prev = cur;
      if (++guard > 5000) return;
    end
    forever begin
      hi += cur ? 1 : 0;
      per++;
      prev = cur;
      @(negedge clk); #1 cur = pwm_out[n];
      if (!prev && cur) break;
      if (per > 5000) return;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int hi, per;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 18; a++) begin
      rd(5'(a), d);
      check("R1 reset register", d, 32'd0);
    end
    check("R1 reset pins", 32'(pwm_out), 32'd0);

    // R2: readback through the map
    d2 = $urandom; wr(5'd0, d2); rd(5'd0, d); check("R2 prescaler word", d, d2 & 32'hFFFF);
    d2 = $urandom; wr(5'd1, d2); rd(5'd1, d); check("R2 divider word", d, d2 & 32'hFFFFF);
    for (int n = 0; n < 5; n++) begin
      d2 = $urandom; wr(a_rel(n), d2); rd(a_rel(n), d); check("R2 reload buffer", d, d2);
      if (n < 4) begin
        d2 = $urandom; wr(a_cmp(n), d2); rd(a_cmp(n), d); check("R2 compare buffer", d, d2);
      end
    end
    wr(5'd0, 0); wr(5'd1, 0);

    // R3: load bit copies the reload buffer to the live count
    wr(a_rel(0), 32'd12345);
    wr(5'd2, 32'h2);
    @(negedge clk);
    rd(a_live(0), d); check("R3 load copies buffer", d, 32'd12345);
    wr(5'd2, 32'h0);
    // R7: not running, count stays
    repeat (20) @(negedge clk);
    rd(a_live(0), d); check("R7 frozen while stopped", d, 32'd12345);

    // R10: writing a live-count address changes nothing
    wr(a_live(0), 32'hDEAD_BEEF);
    rd(a_live(0), d); check("R10 live count unchanged", d, 32'd12345);
    rd(a_rel(0), d);  check("R10 reload buffer unchanged", d, 32'd12345);

    // R4: tick rate over random prescaler / divider pairs on channel 2
    for (int i = 0; i < 5; i++) begin
      int p, code, t;
      p = $urandom_range(0, 5);
      code = (i == 0) ? 4 : $urandom_range(0, 4);
      t = tick_len(p, code);
      arm(2, 32'h00FF_FFFF, 0, p, code, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      rd(a_live(2), d);
      repeat (6 * t) @(negedge clk);
      rd(a_live(2), d2);
      check("R4 ticks in window", d - d2, 32'd6);
    end
    ctl = '0; wr(5'd2, ctl);

    // R5 / R12: period and high time on channel 1 (group 0) and channel 3
    for (int i = 0; i < 4; i++) begin
      int nv, cv, ch;
      ch = (i % 2 == 0) ? 1 : 3;
      nv = $urandom_range(4, 40);
      cv = $urandom_range(0, nv - 1);
      arm(ch, nv, cv, 0, 0, 1'b1, 1'b0);
      measure(ch, hi, per);
      check("R5 period ticks", per, nv + 1);
      check("R5 high ticks", hi, exp_high(nv, cv, 1'b0));
    end
    // R5 with a prescaler and divider: period scales by the tick length
    arm(1, 9, 3, 2, 1, 1'b1, 1'b0);
    measure(1, hi, per);
    check("R5 scaled period", per, 10 * tick_len(2, 1));
    check("R5 scaled high", hi, exp_high(9, 3, 1'b0) * tick_len(2, 1));

    // R6: inverted output
    arm(1, 20, 6, 0, 0, 1'b1, 1'b1);
    measure(1, hi, per);
    check("R6 inverted period", per, 21);
    check("R6 inverted high", hi, exp_high(20, 6, 1'b1));

    // R7: stopping mid-run freezes the count, pin goes to inverted idle
    ctl[runb(1)] = 1'b0; wr(5'd2, ctl);
    rd(a_live(1), d);
    repeat (25) @(negedge clk);
    rd(a_live(1), d2);
    check("R7 stopped count stable", d2, d);
    check("R7 inverted idle pin", 32'(pwm_out[1]), 32'd1);
    ctl = '0; wr(5'd2, ctl);
    #1 check("R7 plain idle pin", 32'(pwm_out), 32'd0);

    // R8 / R9: one-shot on channel 0
    wr(5'd17, 32'h1F);
    arm(0, 5, 2, 0, 0, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    rd(a_live(0), d); check("R8 one-shot parks at zero", d, 32'd0);
    rd(5'd17, d);     check("R9 zero flag set", d & 32'h1, 32'd1);
    wr(5'd17, 32'h1);
    repeat (10) @(negedge clk);
    rd(5'd17, d);     check("R9 flag cleared by write-one", d & 32'h1, 32'd0);
    rd(a_live(0), d); check("R8 still at zero", d, 32'd0);

    // R11: channel 4 at bits 20..22, reloading countdown, no pin
    ctl = '0; wr(5'd2, ctl); wr(5'd17, 32'h1F);
    arm(4, 7, 0, 0, 0, 1'b1, 1'b0);
    check("R11 control bits", ctl, 32'h0050_0000);
    repeat (30) @(negedge clk);
    rd(5'd17, d); check("R11 channel 4 flag", d, 32'h10);
    rd(a_live(4), d);
    check("R11 count within reload range", 32'(d <= 7), 32'd1);
    check("R11 no pin activity", 32'(pwm_out), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule